// File: doc/BRIEF.md
# Shifting Queue Read Port

This block sits on the read path of a bank of display queues. Each byte leaving a queue toward the host passes through it and may be rotated by one bit through a single carry flag that all queues share. A display kernel can therefore scroll a playfield sideways by one pixel per frame while it reads the data. The queue memory is never rewritten for this. Each queue has its own transform mode and its own bit index, held in a small register file that configuration writes load.

Two of the modes work on the upper half of the byte only. They suit a four-bit playfield register: the carry enters or leaves at the middle bit, and the lower half of the result is zero. A bit-grab mode reads the queue only to load one chosen bit into the carry. In that mode the host receives a programmable substitute byte instead of the queue data. The carry can also be set or cleared directly. The transformed byte is combinational from the raw byte. The carry updates on the clock edge that ends the read cycle.

Top module: `qshift_port`

## Requirements
- R1: Mode code 0 (pass) returns the raw byte unchanged. Any cycle without a read or a carry write leaves the carry unchanged. After reset every queue is in mode 0 with bit index 0, and the carry is 0.
- R2: Mode code 1 (left full) outputs {raw[6:0], carry} and loads raw[7] into the carry at the edge.
- R3: Mode code 2 (right full) outputs {carry, raw[7:1]} and loads raw[0] into the carry.
- R4: Mode code 3 (left half) outputs {raw[6:4], carry, 4'h0} and loads raw[7] into the carry.
- R5: Mode code 4 (right half) outputs {carry, raw[7:5], 4'h0} and loads raw[4] into the carry.
- R6: Mode code 5 (bit grab) outputs the substitute byte and loads raw[b] into the carry, where b is the queue's 3-bit index. The substitute byte resets to 8'h00 and is loaded by a substitute write.
- R7: A carry write sets the carry to its data bit at the next edge. When a carry write and a read occur in the same cycle, the carry write wins.
- R8: A configuration write changes only the addressed queue's mode and bit index. Every other queue keeps its setting.
- R9: Mode codes 6 and 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write mode and bit index of one queue |
| cfg_queue | input | 4 | Queue addressed by the configuration write |
| cfg_mode | input | 3 | Mode code to store |
| cfg_bit | input | 3 | Bit index to store |
| subst_we | input | 1 | Load the substitute byte |
| subst_data | input | 8 | Substitute byte value |
| carry_we | input | 1 | Direct write of the carry |
| carry_data | input | 1 | Carry value to write |
| rd_en | input | 1 | A queue read is in progress this cycle |
| rd_queue | input | 4 | Queue being read |
| rd_raw | input | 8 | Raw byte from the queue |
| rd_out | output | 8 | Transformed byte to the host |
| carry_out | output | 1 | Current carry flag |

## Verification
A corrupted mode entry shows on rd_out in the same cycle that its queue is read. It also shows on the carry one edge later. A wrong carry has a delay: it stays hidden through pass reads. It shows on the very next shifting read, where the carry enters bit 0, bit 7 or the middle bit. For that reason the bench follows each carry-changing read with a read that exposes the carry, and it checks carry_out after every edge. A configuration write that reaches the wrong queue appears only when the neighbouring queue is read, so reads of the untouched queues follow each such write.

// File: rtl/qshift_pkg.sv
package qshift_pkg;
   typedef enum logic [2:0] {
      MD_PASS     = 3'd0,
      MD_SHL      = 3'd1,
      MD_SHR      = 3'd2,
      MD_SHL_HALF = 3'd3,
      MD_SHR_HALF = 3'd4,
      MD_GRAB     = 3'd5
   } qmode_e;
   localparam int MODE_W = 3;
endpackage

// File: rtl/qshift_mode_file.sv
module qshift_mode_file #(
   parameter int NUM_Q = 16,
   parameter int QW    = 4,
   parameter int BW    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [QW-1:0]                 wr_q,
   input  logic [qshift_pkg::MODE_W-1:0] wr_mode,
   input  logic [BW-1:0]                 wr_bit,
   input  logic [QW-1:0]                 rd_q,
   output logic [qshift_pkg::MODE_W-1:0] rd_mode,
   output logic [BW-1:0]                 rd_bit
);
   localparam int MW = qshift_pkg::MODE_W;

   logic [MW-1:0] mode_q [NUM_Q];
   logic [BW-1:0] bit_q  [NUM_Q];

   for (genvar g = 0; g < NUM_Q; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q[g] <= MW'(qshift_pkg::MD_PASS);
            bit_q[g]  <= '0;
         end else if (wr_en && (wr_q == QW'(g))) begin
            mode_q[g] <= wr_mode;
            bit_q[g]  <= wr_bit;
         end
      end
   end

   if (NUM_Q == 1) begin : g_single
      assign rd_mode = mode_q[0];
      assign rd_bit  = bit_q[0];
   end else begin : g_multi
      assign rd_mode = mode_q[rd_q];
      assign rd_bit  = bit_q[rd_q];
   end
endmodule

// File: rtl/qshift_xform.sv
module qshift_xform #(
   parameter int DW = 8,
   parameter int BW = 3
) (
   input  logic [DW-1:0]                 raw,
   input  logic [qshift_pkg::MODE_W-1:0] mode,
   input  logic [BW-1:0]                 bit_sel,
   input  logic                          cin,
   input  logic [DW-1:0]                 subst,
   output logic [DW-1:0]                 dout,
   output logic                          cout,
   output logic                          cload
);
   import qshift_pkg::*;
   localparam int HP = DW / 2;

   always_comb begin
      dout  = raw;
      cout  = cin;
      cload = 1'b1;
      case (mode)
         MD_SHL: begin
            dout = {raw[DW-2:0], cin};
            cout = raw[DW-1];
         end
         MD_SHR: begin
            dout = {cin, raw[DW-1:1]};
            cout = raw[0];
         end
         MD_SHL_HALF: begin
            dout = '0;
            dout[DW-1:HP+1] = raw[DW-2:HP];
            dout[HP]        = cin;
            cout            = raw[DW-1];
         end
         MD_SHR_HALF: begin
            dout = '0;
            dout[DW-1]      = cin;
            dout[DW-2:HP]   = raw[DW-1:HP+1];
            cout            = raw[HP];
         end
         MD_GRAB: begin
            dout = subst;
            cout = raw[bit_sel];
         end
         default: cload = 1'b0;
      endcase
   end
endmodule

// File: rtl/qshift_carry.sv
module qshift_carry #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_we,
   input  logic          set_val,
   input  logic          rd_load,
   input  logic          rd_val,
   input  logic          sub_we,
   input  logic [DW-1:0] sub_val,
   output logic          carry,
   output logic [DW-1:0] subst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry <= 1'b0;
         subst <= '0;
      end else begin
         if (set_we)       carry <= set_val;
         else if (rd_load) carry <= rd_val;
         if (sub_we)       subst <= sub_val;
      end
   end
endmodule

// File: rtl/qshift_port.sv
module qshift_port #(
   parameter int NUM_QUEUES = 16,
   parameter int DATA_W     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [$clog2(NUM_QUEUES)-1:0] cfg_queue,
   input  logic [2:0]                    cfg_mode,
   input  logic [$clog2(DATA_W)-1:0]     cfg_bit,
   input  logic                          subst_we,
   input  logic [DATA_W-1:0]             subst_data,
   input  logic                          carry_we,
   input  logic                          carry_data,
   input  logic                          rd_en,
   input  logic [$clog2(NUM_QUEUES)-1:0] rd_queue,
   input  logic [DATA_W-1:0]             rd_raw,
   output logic [DATA_W-1:0]             rd_out,
   output logic                          carry_out
);
   localparam int QW = $clog2(NUM_QUEUES);
   localparam int BW = $clog2(DATA_W);

   initial begin
      if (DATA_W < 4 || (DATA_W % 2) != 0)
         $error("qshift_port: DATA_W must be even and at least 4");
      if (NUM_QUEUES < 2)
         $error("qshift_port: NUM_QUEUES must be at least 2");
   end

   logic [2:0]        sel_mode;
   logic [BW-1:0]     sel_bit;
   logic [DATA_W-1:0] subst_q;
   logic              carry_q;
   logic              nxt_carry;
   logic              nxt_load;

   qshift_mode_file #(.NUM_Q(NUM_QUEUES), .QW(QW), .BW(BW)) u_modes (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_q    (cfg_queue),
      .wr_mode (cfg_mode),
      .wr_bit  (cfg_bit),
      .rd_q    (rd_queue),
      .rd_mode (sel_mode),
      .rd_bit  (sel_bit)
   );

   qshift_xform #(.DW(DATA_W), .BW(BW)) u_xform (
      .raw     (rd_raw),
      .mode    (sel_mode),
      .bit_sel (sel_bit),
      .cin     (carry_q),
      .subst   (subst_q),
      .dout    (rd_out),
      .cout    (nxt_carry),
      .cload   (nxt_load)
   );

   qshift_carry #(.DW(DATA_W)) u_carry (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (carry_we),
      .set_val (carry_data),
      .rd_load (rd_en && nxt_load),
      .rd_val  (nxt_carry),
      .sub_we  (subst_we),
      .sub_val (subst_data),
      .carry   (carry_q),
      .subst   (subst_q)
   );

   assign carry_out = carry_q;
endmodule

// File: rtl/qshift_port_chk.sv
module qshift_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              carry_we,
   input logic              carry_data,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_raw,
   input logic [DATA_W-1:0] rd_out,
   input logic              carry_out,
   input logic [2:0]        sel_mode,
   input logic [DATA_W-1:0] subst_q
);
   localparam int HP = DATA_W / 2;

   AST_PASS_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !carry_we && sel_mode == 3'd0) |=> $stable(carry_out)); // R1
   AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_mode == 3'd0) |-> rd_out == rd_raw); // R1
   AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !carry_we && sel_mode == 3'd1) |=> carry_out == $past(rd_raw[DATA_W-1])); // R2
   AST_RIGHT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !carry_we && sel_mode == 3'd2) |=> carry_out == $past(rd_raw[0])); // R3
   AST_HALF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (sel_mode == 3'd3 || sel_mode == 3'd4)) |-> rd_out[HP-1:0] == '0); // R4
   AST_RHALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !carry_we && sel_mode == 3'd4) |=> carry_out == $past(rd_raw[HP])); // R5
   AST_GRAB_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_mode == 3'd5) |-> rd_out == subst_q); // R6
   AST_CARRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      carry_we |=> carry_out == $past(carry_data)); // R7
   AST_IDLE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !carry_we) |=> $stable(carry_out)); // R1
endmodule

bind qshift_port qshift_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .carry_we   (carry_we),
   .carry_data (carry_data),
   .rd_en      (rd_en),
   .rd_raw     (rd_raw),
   .rd_out     (rd_out),
   .carry_out  (carry_out),
   .sel_mode   (sel_mode),
   .subst_q    (subst_q)
);

// File: tb/qshift_port_test.sv
module qshift_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_queue = '0;
   logic [2:0] cfg_mode = '0;
   logic [2:0] cfg_bit = '0;
   logic       subst_we = 1'b0;
   logic [7:0] subst_data = '0;
   logic       carry_we = 1'b0;
   logic       carry_data = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] rd_queue = '0;
   logic [7:0] rd_raw = '0;
   logic [7:0] rd_out;
   logic       carry_out;

   always #2.5 clk = ~clk;

   qshift_port uut (.*);

   typedef struct {
      bit         is_carry;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sbq[$];
   event  mon_ev;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;

   logic       ref_c = 1'b0;
   logic [7:0] ref_sub = 8'h00;
   logic [2:0] ref_mode [16];
   logic [2:0] ref_bit  [16];

   // monitor: pops expected items and compares them with the ports
   initial forever begin
      @(mon_ev);
      while (sbq.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sbq.pop_front();
         act = it.is_carry ? {7'd0, carry_out} : rd_out;
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", it.req,
                     it.is_carry ? "carry" : "data", act, it.exp);
         end
      end
   end

   task automatic push(bit c, logic [7:0] v, string r);
      item_t it;
      it.is_carry = c; it.exp = v; it.req = r;
      sbq.push_back(it);
   endtask

   task automatic cfg(int q, logic [2:0] m, logic [2:0] b);
      @(negedge clk);
      cfg_we = 1; cfg_queue = 4'(q); cfg_mode = m; cfg_bit = b;
      @(negedge clk);
      cfg_we = 0;
      ref_mode[q] = m; ref_bit[q] = b;
   endtask

   task automatic set_sub(logic [7:0] v);
      @(negedge clk);
      subst_we = 1; subst_data = v;
      @(negedge clk);
      subst_we = 0;
      ref_sub = v;
   endtask

   task automatic set_carry(logic v, string r);
      @(negedge clk);
      carry_we = 1; carry_data = v;
      @(posedge clk); #1;
      carry_we = 0;
      ref_c = v;
      push(1, {7'd0, ref_c}, r); -> mon_ev;
   endtask

   // read driver: computes the expected byte and carry from the requirements
   task automatic rd(int q, logic [7:0] raw, string r, bit also_cw = 0, logic cw = 0);
      logic [7:0] e;
      logic       nc;
      @(negedge clk);
      rd_en = 1; rd_queue = 4'(q); rd_raw = raw;
      carry_we = also_cw; carry_data = cw;
      e = raw; nc = ref_c;
      case (ref_mode[q])
         3'd1: begin e = {raw[6:0], ref_c}; nc = raw[7]; end
         3'd2: begin e = {ref_c, raw[7:1]}; nc = raw[0]; end
         3'd3: begin e = {raw[6:4], ref_c, 4'h0}; nc = raw[7]; end
         3'd4: begin e = {ref_c, raw[7:5], 4'h0}; nc = raw[4]; end
         3'd5: begin e = ref_sub; nc = raw[ref_bit[q]]; end
         default: ;
      endcase
      if (also_cw) nc = cw;
      #1;
      push(0, e, r); -> mon_ev;
      @(posedge clk); #1;
      rd_en = 0; carry_we = 0;
      ref_c = nc;
      push(1, {7'd0, ref_c}, r); -> mon_ev;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin ref_mode[i] = 3'd0; ref_bit[i] = 3'd0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state: carry 0, all queues pass
      #1 push(1, 8'h00, "R1"); -> mon_ev;
      rd(0, 8'hA5, "R1");
      rd(15, 8'h3C, "R1");
      // R7 carry set and clear
      set_carry(1, "R7");
      rd(0, 8'h00, "R1");               // pass keeps carry 1
      set_carry(0, "R7");
      set_carry(1, "R7");
      // R2 left full, rotate a pattern around
      cfg(1, 3'd1, 3'd0);
      rd(1, 8'h80, "R2");
      rd(1, 8'h00, "R2");
      rd(1, 8'h55, "R2");
      rd(1, 8'hFE, "R2");
      // R3 right full
      cfg(2, 3'd2, 3'd0);
      rd(2, 8'h01, "R3");
      rd(2, 8'h00, "R3");
      rd(2, 8'hAA, "R3");
      // R4 left half
      cfg(3, 3'd3, 3'd0);
      set_carry(1, "R7");
      rd(3, 8'h7F, "R4");
      rd(3, 8'h9A, "R4");
      rd(3, 8'h0F, "R4");
      // R5 right half
      cfg(4, 3'd4, 3'd0);
      set_carry(1, "R7");
      rd(4, 8'hF0, "R5");
      rd(4, 8'h2F, "R5");
      rd(4, 8'h1E, "R5");
      // R6 bit grab: substitute resets to 00, then programmed
      cfg(5, 3'd5, 3'd6);
      rd(5, 8'h40, "R6");
      rd(5, 8'hBF, "R6");
      set_sub(8'h5A);
      rd(5, 8'hFF, "R6");
      cfg(5, 3'd5, 3'd2);
      rd(5, 8'h04, "R6");
      rd(5, 8'hFB, "R6");
      // R8 neighbours untouched by configuration writes
      rd(6, 8'h81, "R8");
      rd(0, 8'h81, "R8");
      rd(1, 8'h81, "R8");
      // R7 priority of carry write over a read
      rd(1, 8'h80, "R7", 1, 0);
      rd(2, 8'h00, "R7", 1, 1);
      // R9 undefined codes behave as pass
      cfg(7, 3'd6, 3'd1);
      cfg(8, 3'd7, 3'd1);
      rd(7, 8'hC3, "R9");
      rd(8, 8'h3C, "R9");
      rd(7, 8'h01, "R9");
      // R1 idle cycles keep carry
      repeat (3) @(posedge clk);
      #1 push(1, {7'd0, ref_c}, "R1"); -> mon_ev;
      #1;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule